// File: doc/BRIEF.md
# Display Engine Clock and Reset Controller

This block sits beside a display engine and supplies its four sub-units (two mixers, a write-back unit and a transform unit) with clock enables, bus clock enables and active-low resets. Software programs it through a small 32-bit register port. It has separate registers for module gating, bus gating, reset release, per-unit clock division and mixer-to-timing-controller routing. There is only one input clock. Each unit's slower module clock is a one-cycle enable strobe that repeats every (N+1) input cycles, where N is that unit's 4-bit divider field.

The routing register chooses which mixer feeds each of the two timing controllers. The block reports this choice as a source index for each controller. A build parameter ties mixer 1's reset to the write-back reset bit as well as to its own bit. This suits integrations where those two units share a reset line.

Top module: `dispclk_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 (module gate), 0x04 (bus gate), 0x08 (reset release), 0x0C (divider) and 0x10 (routing). A write through the port takes effect at the next clock edge and reads back on `cfg_rdata`.
- R2: In the gate, bus-gate and reset registers, bit 0 is mixer 0, bit 1 mixer 1, bit 2 write-back and bit 3 transform. Bits 31:4 read as zero. The divider register reads zero above bit 15 and the routing register reads zero above bit 0. An unmapped offset reads zero, and a write to it changes no register.
- R3: After reset every register is zero. Every `mod_ce`, `bus_ce` and `unit_rst_n` bit is low.
- R4: Divider fields are bits 3:0 (mixer 0), 7:4 (mixer 1), 11:8 (write-back) and 15:12 (transform). Once running, `div_stb[i]` is high for one cycle in every field+1 cycles.
- R5: With a field value of 0, the strobe is high in every cycle. This includes the state straight after reset.
- R6: A rewritten divider field is taken up only when the current period ends. Every strobe interval equals either the old or the new ratio, and no old interval follows a new one.
- R7: `mod_ce[i]` is high exactly when the unit's module gate bit is set, its reset is released and `div_stb[i]` is high.
- R8: `bus_ce[i]` follows the bus gate bit and does not depend on the reset register.
- R9: `unit_rst_n[i]` is the reset register bit, where 1 releases the unit.
- R10: With routing bit 0 at 0, `tc0_src`=0 and `tc1_src`=1. With bit 0 at 1, `tc0_src`=1 and `tc1_src`=0.
- R11: With `SHARED_MIX1_RST`=1, mixer 1 is released only when reset bits 1 and 2 are both set. The write-back unit still follows bit 2 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| mod_ce | output | 4 | Per-unit gated module clock enable |
| bus_ce | output | 4 | Per-unit bus clock enable |
| unit_rst_n | output | 4 | Per-unit active-low reset |
| div_stb | output | 4 | Per-unit divided strobe before gating |
| tc0_src | output | 1 | Mixer index feeding timing controller 0 |
| tc1_src | output | 1 | Mixer index feeding timing controller 1 |

## Verification
A divider rewrite can land in the same cycle as that divider's period boundary, where the counter reloads from the field. The bench runs a divider at ratio 6 and rewrites the field to ratio 3 at each of six consecutive phases. One of these phases places the write exactly on the reload edge. For every phase it logs the strobe intervals. It judges the run correct only if each interval is 6 or 3, no 6 follows a 3, and the run ends on 3.

// File: rtl/dispclk_pkg.sv
package dispclk_pkg;
    localparam int UNITS   = 4;
    localparam int DIV_W   = 4;
    localparam int DIV_TOT = UNITS * DIV_W;
    localparam int DATA_W  = 32;

    localparam int U_MIX0  = 0;
    localparam int U_MIX1  = 1;
    localparam int U_WB    = 2;
    localparam int U_XFORM = 3;

    localparam int OFS_GATE  = 'h00;
    localparam int OFS_BUS   = 'h04;
    localparam int OFS_REL   = 'h08;
    localparam int OFS_DIV   = 'h0C;
    localparam int OFS_ROUTE = 'h10;

    typedef struct packed {
        logic [UNITS-1:0]   gate;
        logic [UNITS-1:0]   bus;
        logic [UNITS-1:0]   rel;
        logic [DIV_TOT-1:0] div;
        logic               swap;
    } dck_regs_t;
endpackage

// File: rtl/dispclk_regs.sv
module dispclk_regs
    import dispclk_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output dck_regs_t         regs_o
);
    dck_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            if (addr_i == ADDR_W'(OFS_GATE))  r_d.gate = wdata_i[UNITS-1:0];
            if (addr_i == ADDR_W'(OFS_BUS))   r_d.bus  = wdata_i[UNITS-1:0];
            if (addr_i == ADDR_W'(OFS_REL))   r_d.rel  = wdata_i[UNITS-1:0];
            if (addr_i == ADDR_W'(OFS_DIV))   r_d.div  = wdata_i[DIV_TOT-1:0];
            if (addr_i == ADDR_W'(OFS_ROUTE)) r_d.swap = wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_GATE))  rdata_o[UNITS-1:0]   = r_q.gate;
        if (addr_i == ADDR_W'(OFS_BUS))   rdata_o[UNITS-1:0]   = r_q.bus;
        if (addr_i == ADDR_W'(OFS_REL))   rdata_o[UNITS-1:0]   = r_q.rel;
        if (addr_i == ADDR_W'(OFS_DIV))   rdata_o[DIV_TOT-1:0] = r_q.div;
        if (addr_i == ADDR_W'(OFS_ROUTE)) rdata_o[0]           = r_q.swap;
    end

    assign regs_o = r_q;

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(OFS_GATE)) |-> (rdata_o[DATA_W-1:UNITS] == '0));

    // R1
    route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_W'(OFS_ROUTE)) |=> (regs_o.swap == $past(wdata_i[0])));
endmodule

// File: rtl/dispclk_div.sv
module dispclk_div #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_i,
    output logic         stb_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == '0) cnt_d = ratio_i;
        else             cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stb_o = (cnt_q == '0);

    // R6
    reload_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o |=> (cnt_q == $past(ratio_i)));

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_o |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dispclk_ctrl.sv
module dispclk_ctrl
    import dispclk_pkg::*;
#(
    parameter int ADDR_W          = 5,
    parameter bit SHARED_MIX1_RST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic [3:0]        mod_ce,
    output logic [3:0]        bus_ce,
    output logic [3:0]        unit_rst_n,
    output logic [3:0]        div_stb,
    output logic              tc0_src,
    output logic              tc1_src
);
    dck_regs_t regs;

    dispclk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .regs_o  (regs)
    );

    logic [UNITS-1:0] released;

    for (genvar i = 0; i < UNITS; i++) begin : g_unit
        dispclk_div #(.W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .ratio_i (regs.div[i*DIV_W +: DIV_W]),
            .stb_o   (div_stb[i])
        );

        if (i == U_MIX1 && SHARED_MIX1_RST) begin : g_shared
            assign released[i] = regs.rel[U_MIX1] & regs.rel[U_WB];
        end else begin : g_own
            assign released[i] = regs.rel[i];
        end

        assign mod_ce[i] = regs.gate[i] & released[i] & div_stb[i];

        // R7
        modce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mod_ce[i] |-> (regs.gate[i] && unit_rst_n[i] && div_stb[i]));
    end

    assign unit_rst_n = released;
    assign bus_ce     = regs.bus;
    assign tc0_src    = regs.swap;
    assign tc1_src    = ~regs.swap;

    // R10
    route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc0_src != tc1_src);

    // R11
    mix1_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SHARED_MIX1_RST && !regs.rel[U_WB]) |-> !unit_rst_n[U_MIX1]);

    // R8
    bus_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == ADDR_W'(OFS_BUS)) |=> (bus_ce == $past(cfg_wdata[3:0])));
endmodule

// File: tb/dispclk_ctrl_test.sv
module dispclk_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, cfg_rdata_s;
    logic [3:0]  mod_ce, bus_ce, unit_rst_n, div_stb;
    logic [3:0]  mod_ce_s, bus_ce_s, unit_rst_n_s, div_stb_s;
    logic        tc0_src, tc1_src, tc0_src_s, tc1_src_s;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    dispclk_ctrl #(.ADDR_W(5), .SHARED_MIX1_RST(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mod_ce(mod_ce),
        .bus_ce(bus_ce), .unit_rst_n(unit_rst_n), .div_stb(div_stb),
        .tc0_src(tc0_src), .tc1_src(tc1_src)
    );

    dispclk_ctrl #(.ADDR_W(5), .SHARED_MIX1_RST(1'b1)) uut_sh (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata_s), .mod_ce(mod_ce_s),
        .bus_ce(bus_ce_s), .unit_rst_n(unit_rst_n_s), .div_stb(div_stb_s),
        .tc0_src(tc0_src_s), .tc1_src(tc1_src_s)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a <= 'h10; a += 4) begin
            rd(5'(a), v);
            check("R3 reg zero after reset", v, 32'h0);
        end
        check("R3 mod_ce off", {28'h0, mod_ce}, 32'h0);
        check("R3 bus_ce off", {28'h0, bus_ce}, 32'h0);
        check("R3 units held in reset", {28'h0, unit_rst_n}, 32'h0);
        check("R5 strobe every cycle at ratio 1", {28'h0, div_stb}, 32'hF);
        check("R10 default routing", {30'h0, tc0_src, tc1_src}, 32'h1);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, v);
        check("R1 R2 gate readback, upper zero", v, 32'hF);
        wr(5'h04, 32'hFFFF_FFF5); rd(5'h04, v);
        check("R1 R2 bus gate readback", v, 32'h5);
        wr(5'h0C, 32'hABCD_1234); rd(5'h0C, v);
        check("R1 R2 divider readback", v, 32'h1234);
        wr(5'h10, 32'hFFFF_FFFE); rd(5'h10, v);
        check("R1 R2 routing readback", v, 32'h0);
        wr(5'h14, 32'hFFFF_FFFF); rd(5'h14, v);
        check("R2 unmapped reads zero", v, 32'h0);
        rd(5'h00, v);
        check("R2 unmapped write leaves gate", v, 32'hF);
        rd(5'h08, v);
        check("R2 unmapped write leaves reset reg", v, 32'h0);
        wr(5'h00, 32'h0); wr(5'h04, 32'h0); wr(5'h0C, 32'h0);
    endtask

    task automatic t_bus();
        wr(5'h08, 32'h0);
        wr(5'h04, 32'h5);
        check("R8 bus_ce with units in reset", {28'h0, bus_ce}, 32'h5);
        wr(5'h04, 32'hA);
        check("R8 bus_ce other pattern", {28'h0, bus_ce}, 32'hA);
        wr(5'h04, 32'h0);
    endtask

    task automatic t_rst();
        wr(5'h08, 32'h9);
        check("R9 reset release bits", {28'h0, unit_rst_n}, 32'h9);
        wr(5'h08, 32'h2);
        check("R9 mixer1 released alone", {28'h0, unit_rst_n}, 32'h2);
        check("R11 shared: mixer1 held without bit2", {28'h0, unit_rst_n_s}, 32'h0);
        wr(5'h08, 32'h4);
        check("R11 shared: bit2 alone frees write-back only", {28'h0, unit_rst_n_s}, 32'h4);
        wr(5'h08, 32'h6);
        check("R11 shared: bits 1 and 2 free mixer1", {28'h0, unit_rst_n_s}, 32'h6);
        wr(5'h08, 32'h0);
    endtask

    task automatic t_div();
        int last[4];
        int bad[4];
        int exp_p[4];
        exp_p = '{2, 6, 1, 4};
        wr(5'h0C, 32'h3051);
        repeat (20) @(negedge clk);
        for (int u = 0; u < 4; u++) begin last[u] = -1; bad[u] = 0; end
        for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            for (int u = 0; u < 4; u++) begin
                if (div_stb[u]) begin
                    if (last[u] >= 0 && (c - last[u]) != exp_p[u]) bad[u] = c - last[u];
                    last[u] = c;
                end
            end
        end
        for (int u = 0; u < 4; u++)
            check(u == 2 ? "R5 ratio-1 field strobes every cycle" : "R4 strobe period = field+1",
                  32'(bad[u]), 32'h0);
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_rewrite();
        for (int ph = 0; ph < 6; ph++) begin
            int last; int prev_iv; int ok;
            wr(5'h0C, 32'h5);
            repeat (20) @(negedge clk);
            last = -1; prev_iv = 6; ok = 1;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (c == ph) begin cfg_wr = 1'b1; cfg_addr = 5'h0C; cfg_wdata = 32'h2; end
                else cfg_wr = 1'b0;
                if (div_stb[0]) begin
                    if (last >= 0) begin
                        int iv;
                        iv = c - last;
                        if (iv != 6 && iv != 3) ok = 0;
                        if (prev_iv == 3 && iv == 6) ok = 0;
                        prev_iv = iv;
                    end
                    last = c;
                end
            end
            cfg_wr = 1'b0;
            if (prev_iv != 3) ok = 0;
            check("R6 rewrite keeps full periods", 32'(ok), 32'h1);
        end
        wr(5'h0C, 32'h0);
    endtask

    task automatic t_modce();
        int bad;
        wr(5'h0C, 32'h0);
        wr(5'h00, 32'h3);
        wr(5'h08, 32'h1);
        check("R7 gate&release: only mixer0", {28'h0, mod_ce}, 32'h1);
        wr(5'h08, 32'hF);
        check("R7 gate&release: mixers", {28'h0, mod_ce}, 32'h3);
        wr(5'h0C, 32'h1);
        bad = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (mod_ce[0] !== div_stb[0]) bad++;
        end
        check("R7 mod_ce follows strobe", 32'(bad), 32'h0);
        wr(5'h00, 32'h0);
        check("R7 gate off", {28'h0, mod_ce}, 32'h0);
        wr(5'h08, 32'h0); wr(5'h0C, 32'h0);
    endtask

    task automatic t_route();
        wr(5'h10, 32'h1);
        check("R10 swapped routing", {30'h0, tc0_src, tc1_src}, 32'h2);
        wr(5'h10, 32'h0);
        check("R10 straight routing", {30'h0, tc0_src, tc1_src}, 32'h1);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_bus();
        t_rst();
        t_div();
        t_rewrite();
        t_modce();
        t_route();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule